// File: doc/BRIEF.md
# Double-to-Unsigned Integer Converter

This unit turns one IEEE-754 binary64 operand into an unsigned integer that is either 32 or 64 bits wide. It rounds by a 2-bit rounding mode. The mode comes either from a global control input or from a per-operation override. Alongside the integer the unit reports two flags: invalid, for a value that cannot be represented, and inexact, for a result that lost fraction bits.

The host presents an operand with `in_valid`. The result, both flags and a matching `out_valid` appear one clock later, with the default registered output. A unit that cannot represent the rounded value returns all ones in the selected width and raises invalid. A 32-bit result always leaves the upper half of `out_res` at zero. Decode, operand fetch, trapping and packed forms are left to the surrounding pipeline.

Top module: `dcvt_u_top`

## Requirements
- R1: The result is 64 bits wide only when `long_mode` and `wide_req` are both 1. In every other case the 32-bit form is produced and `out_res[63:32]` is 0, even when `ovr_en` is 1 and a 64-bit width was requested.
- R2: The rounding mode is `ovr_rc` when `ovr_en` and `src_is_reg` are both 1. Otherwise it is `glb_rc`.
- R3: Rounding-mode encoding: 2'b00 rounds to nearest with ties to even, 2'b01 rounds toward negative infinity, 2'b10 rounds toward positive infinity, 2'b11 truncates toward zero.
- R4: When the rounded magnitude does not fit in the selected width w, invalid is 1 and the result is 2^w-1.
- R5: A NaN or an infinity (exponent field all ones) gives invalid and the all-ones result.
- R6: A negative operand whose rounded magnitude is nonzero is invalid. A negative operand that rounds to zero returns 0, with inexact as its only flag.
- R7: Inexact is 1 exactly when nonzero fraction bits are discarded and the result is valid. It is never 1 together with invalid.
- R8: ±0 returns 0 with no flags. A denormal operand returns 0 with inexact set, in every rounding mode.
- R9: In-range values are converted to the rounded integer. Exact integers come out unchanged with no flags.
- R10: `out_valid` follows `in_valid` by one clock. During reset `out_valid`, `out_res` and both flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand present this cycle |
| in_op | input | 64 | binary64 operand |
| long_mode | input | 1 | 64-bit execution mode active |
| wide_req | input | 1 | 64-bit destination requested |
| ovr_en | input | 1 | Per-operation rounding override enable |
| src_is_reg | input | 1 | Operand came from a register |
| ovr_rc | input | 2 | Per-operation rounding mode |
| glb_rc | input | 2 | Global rounding mode |
| out_valid | output | 1 | Result present |
| out_res | output | 64 | Unsigned integer result |
| out_invalid | output | 1 | Invalid flag |
| out_inexact | output | 1 | Inexact (precision) flag |

## Verification
The bench targets the tie just below 2^32. Rounding to nearest must carry it past the 32-bit limit, so it is invalid there but fits in 64 bits. A converter that checks range before rounding would return 0xFFFFFFFF with no invalid flag. Negative inputs are run under both toward-zero and toward-negative-infinity. This catches a design that rejects every negative number, and one that accepts -0.5 rounded downward. Further cases are the largest binary64 below 2^64 and 2^64 itself, denormals under upward rounding, and a 64-bit request without long mode. The override is also tried with a memory source, where a design that ignores the source gate picks the wrong mode.

// File: rtl/dcvt_pkg.sv
package dcvt_pkg;
   typedef enum logic [1:0] {
      RC_NEAR  = 2'b00,
      RC_DOWN  = 2'b01,
      RC_UP    = 2'b10,
      RC_TRUNC = 2'b11
   } rc_e;
endpackage

// File: rtl/dcvt_mode_sel.sv
module dcvt_mode_sel
   import dcvt_pkg::*;
(
   input  logic       long_mode,
   input  logic       wide_req,
   input  logic       ovr_en,
   input  logic       src_is_reg,
   input  logic [1:0] ovr_rc,
   input  logic [1:0] glb_rc,
   output rc_e        rc,
   output logic       wide
);
   always_comb begin
      rc   = (ovr_en && src_is_reg) ? rc_e'(ovr_rc) : rc_e'(glb_rc);
      wide = long_mode & wide_req;
   end
endmodule

// File: rtl/dcvt_align.sv
module dcvt_align #(
   parameter int EXP_W = 11,
   parameter int MAN_W = 52,
   parameter int INT_W = 64,
   localparam int FP_W  = 1 + EXP_W + MAN_W,
   localparam int BIAS  = (1 << (EXP_W - 1)) - 1,
   localparam int FRC_W = MAN_W + 2,
   localparam int SPN_W = INT_W + FRC_W
) (
   input  logic [FP_W-1:0]  op,
   output logic             sign,
   output logic             nan_inf,
   output logic             is_zero,
   output logic             is_denorm,
   output logic             too_big,
   output logic [INT_W-1:0] int_part,
   output logic             rbit,
   output logic             sticky
);
   logic [EXP_W-1:0] exp_f;
   logic [MAN_W-1:0] man_f;
   logic [SPN_W-1:0] span;
   logic [7:0]       sh;
   int               e;

   always_comb begin
      sign      = op[FP_W-1];
      exp_f     = op[FP_W-2 -: EXP_W];
      man_f     = op[MAN_W-1:0];
      nan_inf   = &exp_f;
      is_zero   = (exp_f == '0) && (man_f == '0);
      is_denorm = (exp_f == '0) && (man_f != '0);
      e         = int'(exp_f) - BIAS;
      too_big   = !nan_inf && (exp_f != '0) && (e >= INT_W);
      span      = '0;
      sh        = '0;
      int_part  = '0;
      rbit      = 1'b0;
      sticky    = 1'b0;
      if (exp_f != '0 && !nan_inf && !too_big) begin
         if (e >= -2) begin
            sh       = 8'(e + 2);
            span     = {{(INT_W + 1){1'b0}}, 1'b1, man_f} << sh;
            int_part = span[SPN_W-1 -: INT_W];
            rbit     = span[FRC_W-1];
            sticky   = |span[FRC_W-2:0];
         end else begin
            sticky = 1'b1;
         end
      end
   end
endmodule

// File: rtl/dcvt_round.sv
module dcvt_round
   import dcvt_pkg::*;
#(
   parameter int INT_W    = 64,
   parameter int NARROW_W = 32
) (
   input  logic [INT_W-1:0] int_part,
   input  logic             rbit,
   input  logic             sticky,
   input  logic             sign,
   input  rc_e              rc,
   input  logic             wide,
   output logic [INT_W:0]   mag,
   output logic             range_bad,
   output logic             lost
);
   logic inc;
   always_comb begin
      lost = rbit | sticky;
      unique case (rc)
         RC_NEAR:  inc = rbit & (sticky | int_part[0]);
         RC_DOWN:  inc = sign & lost;
         RC_UP:    inc = ~sign & lost;
         default:  inc = 1'b0;
      endcase
      mag       = {1'b0, int_part} + {{INT_W{1'b0}}, inc};
      range_bad = wide ? mag[INT_W] : (mag[INT_W:NARROW_W] != '0);
   end
endmodule

// File: rtl/dcvt_u_top.sv
module dcvt_u_top
   import dcvt_pkg::*;
#(
   parameter int EXP_W    = 11,
   parameter int MAN_W    = 52,
   parameter int INT_W    = 64,
   parameter int NARROW_W = 32,
   parameter bit REG_OUT  = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        in_valid,
   input  logic [63:0] in_op,
   input  logic        long_mode,
   input  logic        wide_req,
   input  logic        ovr_en,
   input  logic        src_is_reg,
   input  logic [1:0]  ovr_rc,
   input  logic [1:0]  glb_rc,
   output logic        out_valid,
   output logic [63:0] out_res,
   output logic        out_invalid,
   output logic        out_inexact
);
   localparam int FP_W = 1 + EXP_W + MAN_W;
   localparam logic [INT_W-1:0] ONES_N = {{(INT_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

   if (FP_W != 64)         begin : g_chk_fp  $error("operand must be 64 bits");     end
   if (INT_W != 64)        begin : g_chk_int $error("result port is 64 bits");      end
   if (NARROW_W >= INT_W)  begin : g_chk_nar $error("narrow width below wide");     end

   rc_e               rc;
   logic              wide, sign, nan_inf, is_zero, is_denorm, too_big;
   logic              rbit, sticky, range_bad, lost;
   logic [INT_W-1:0]  int_part;
   logic [INT_W:0]    mag;
   logic [INT_W-1:0]  c_res;
   logic              c_inv, c_inx;

   dcvt_mode_sel u_sel (
      .long_mode(long_mode), .wide_req(wide_req), .ovr_en(ovr_en),
      .src_is_reg(src_is_reg), .ovr_rc(ovr_rc), .glb_rc(glb_rc),
      .rc(rc), .wide(wide)
   );

   dcvt_align #(.EXP_W(EXP_W), .MAN_W(MAN_W), .INT_W(INT_W)) u_aln (
      .op(in_op), .sign(sign), .nan_inf(nan_inf), .is_zero(is_zero),
      .is_denorm(is_denorm), .too_big(too_big), .int_part(int_part),
      .rbit(rbit), .sticky(sticky)
   );

   dcvt_round #(.INT_W(INT_W), .NARROW_W(NARROW_W)) u_rnd (
      .int_part(int_part), .rbit(rbit), .sticky(sticky), .sign(sign),
      .rc(rc), .wide(wide), .mag(mag), .range_bad(range_bad), .lost(lost)
   );

   always_comb begin
      c_inv = 1'b0;
      c_inx = 1'b0;
      c_res = '0;
      if (nan_inf || too_big) begin
         c_inv = 1'b1;
      end else if (is_denorm) begin
         c_inx = 1'b1;
      end else if (!is_zero) begin
         if (range_bad || (sign && mag != '0)) c_inv = 1'b1;
         else begin
            c_res = mag[INT_W-1:0];
            c_inx = lost;
         end
      end
      if (c_inv) c_res = wide ? '1 : ONES_N;
   end

   if (REG_OUT) begin : g_reg
      logic wide_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            out_valid   <= 1'b0;
            out_res     <= '0;
            out_invalid <= 1'b0;
            out_inexact <= 1'b0;
            wide_q      <= 1'b0;
         end else begin
            out_valid   <= in_valid;
            out_res     <= c_res;
            out_invalid <= c_inv;
            out_inexact <= c_inx;
            wide_q      <= wide;
         end
      end

      AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid |=> out_valid);                                            // R10
      AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
         (out_valid && !wide_q) |-> (out_res[INT_W-1:NARROW_W] == '0));      // R1
      AST_INV_ALLONES: assert property (@(posedge clk) disable iff (!rst_n)
         (out_valid && out_invalid) |-> (out_res == (wide_q ? '1 : ONES_N))); // R4
      AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
         !(out_invalid && out_inexact));                                     // R7
      AST_NEG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && in_op[FP_W-1]) |=> (out_invalid || out_res == '0));    // R6
      AST_NAN_INV: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && (&in_op[FP_W-2 -: EXP_W])) |=> out_invalid);           // R5
   end else begin : g_comb
      always_comb begin
         out_valid   = in_valid;
         out_res     = c_res;
         out_invalid = c_inv;
         out_inexact = c_inx;
      end
   end
endmodule

// File: tb/tb_dcvt_u_top.sv
module tb_dcvt_u_top;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 5000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [63:0] in_op = '0;
   logic        long_mode = 1'b0, wide_req = 1'b0, ovr_en = 1'b0, src_is_reg = 1'b0;
   logic [1:0]  ovr_rc = 2'b00, glb_rc = 2'b00;
   logic        out_valid, out_invalid, out_inexact;
   logic [63:0] out_res;
   int          n_tests = 0, n_fail = 0;
   bit          done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dcvt_u_top dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
      .long_mode(long_mode), .wide_req(wide_req), .ovr_en(ovr_en),
      .src_is_reg(src_is_reg), .ovr_rc(ovr_rc), .glb_rc(glb_rc),
      .out_valid(out_valid), .out_res(out_res),
      .out_invalid(out_invalid), .out_inexact(out_inexact)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp_v);
      n_tests++;
      if (act !== exp_v) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp_v);
      end
   endtask

   // drive one operand and check result one clock later
   task automatic conv(input string tag, input logic [63:0] op, input logic lm,
                       input logic wr, input logic [1:0] grc, input logic oe,
                       input logic sr, input logic [1:0] orc,
                       input logic [63:0] e_res, input logic e_inv, input logic e_inx);
      @(negedge clk);
      in_valid = 1'b1; in_op = op; long_mode = lm; wide_req = wr;
      glb_rc = grc; ovr_en = oe; src_is_reg = sr; ovr_rc = orc;
      @(negedge clk);
      in_valid = 1'b0;
      chk({tag, " valid"},   {63'b0, out_valid},   64'd1);
      chk({tag, " result"},  out_res,              e_res);
      chk({tag, " invalid"}, {63'b0, out_invalid}, {63'b0, e_inv});
      chk({tag, " inexact"}, {63'b0, out_inexact}, {63'b0, e_inx});
   endtask

   task automatic t_reset();
      chk("R10 reset valid", {63'b0, out_valid}, 64'd0);
      chk("R10 reset res",   out_res,            64'd0);
      chk("R10 reset flags", {62'b0, out_invalid, out_inexact}, 64'd0);
   endtask

   task automatic t_exact();
      conv("R9 one",    64'h3FF0000000000000, 1,1, 2'b00, 0,0,2'b00, 64'd1, 0, 0);
      conv("R9 max64",  64'h43EFFFFFFFFFFFFF, 1,1, 2'b00, 0,0,2'b00, 64'hFFFFFFFFFFFFF800, 0, 0);
   endtask

   task automatic t_modes();
      conv("R3 near 2.5",  64'h4004000000000000, 0,0, 2'b00, 0,0,2'b00, 64'd2, 0, 1);
      conv("R3 near 1.5",  64'h3FF8000000000000, 0,0, 2'b00, 0,0,2'b00, 64'd2, 0, 1);
      conv("R3 up 2.5",    64'h4004000000000000, 0,0, 2'b10, 0,0,2'b00, 64'd3, 0, 1);
      conv("R3 down 2.5",  64'h4004000000000000, 0,0, 2'b01, 0,0,2'b00, 64'd2, 0, 1);
      conv("R3 trunc 2.5", 64'h4004000000000000, 0,0, 2'b11, 0,0,2'b00, 64'd2, 0, 1);
      conv("R3 up 0.5",    64'h3FE0000000000000, 0,0, 2'b10, 0,0,2'b00, 64'd1, 0, 1);
   endtask

   task automatic t_override();
      conv("R2 ovr reg", 64'h4004000000000000, 0,0, 2'b11, 1,1,2'b10, 64'd3, 0, 1);
      conv("R2 ovr mem", 64'h4004000000000000, 0,0, 2'b11, 1,0,2'b10, 64'd2, 0, 1);
      conv("R2 no ovr",  64'h4004000000000000, 0,0, 2'b11, 0,1,2'b10, 64'd2, 0, 1);
   endtask

   task automatic t_range();
      conv("R4 tie32 near", 64'h41EFFFFFFFF00000, 0,0, 2'b00, 0,0,2'b00, 64'h00000000FFFFFFFF, 1, 0);
      conv("R4 tie32 trunc",64'h41EFFFFFFFF00000, 0,0, 2'b11, 0,0,2'b00, 64'h00000000FFFFFFFF, 0, 1);
      conv("R1 tie wide",   64'h41EFFFFFFFF00000, 1,1, 2'b00, 0,0,2'b00, 64'h0000000100000000, 0, 1);
      conv("R1 no long",    64'h41F0000000000000, 0,1, 2'b00, 1,1,2'b00, 64'h00000000FFFFFFFF, 1, 0);
      conv("R1 wide 2^32",  64'h41F0000000000000, 1,1, 2'b00, 0,0,2'b00, 64'h0000000100000000, 0, 0);
      conv("R4 2^64",       64'h43F0000000000000, 1,1, 2'b00, 0,0,2'b00, 64'hFFFFFFFFFFFFFFFF, 1, 0);
   endtask

   task automatic t_special();
      conv("R5 nan",       64'h7FF8000000000000, 1,1, 2'b00, 0,0,2'b00, 64'hFFFFFFFFFFFFFFFF, 1, 0);
      conv("R5 inf",       64'h7FF0000000000000, 0,0, 2'b00, 0,0,2'b00, 64'h00000000FFFFFFFF, 1, 0);
      conv("R6 neg one",   64'hBFF0000000000000, 0,0, 2'b11, 0,0,2'b00, 64'h00000000FFFFFFFF, 1, 0);
      conv("R6 neg half",  64'hBFE0000000000000, 0,0, 2'b00, 0,0,2'b00, 64'd0, 0, 1);
      conv("R6 neg dn",    64'hBFE0000000000000, 0,0, 2'b01, 0,0,2'b00, 64'h00000000FFFFFFFF, 1, 0);
      conv("R8 neg zero",  64'h8000000000000000, 0,0, 2'b00, 0,0,2'b00, 64'd0, 0, 0);
      conv("R8 denorm up", 64'h0000000000000001, 0,0, 2'b10, 0,0,2'b00, 64'd0, 0, 1);
      conv("R7 exact two", 64'h4000000000000000, 0,0, 2'b10, 0,0,2'b00, 64'd2, 0, 0);
   endtask

   initial begin
      fork
         begin
            repeat (WATCHDOG) @(posedge clk);
            if (!done) begin
               n_tests++; n_fail++;
               $display("FAIL watchdog: actual timeout expected completion");
               $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
               $finish;
            end
         end
      join_none
      repeat (3) @(posedge clk);
      @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_exact();
      t_modes();
      t_override();
      t_range();
      t_special();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule